// File: doc/BRIEF.md
# I2C Byte Buffer with Transfer Flags

This block is the single-byte holding register that sits between a host bus port and a serial I2C shift engine. Software reads and writes an 8-bit data value through a 16-bit register word. Two flags report buffer state. The transmit-empty flag says the shifter has taken the held byte and a new one may be written. The receive-not-empty flag says a received byte is waiting to be read.

On the shift side, the block offers the held byte to the serializer and accepts completed bytes from the deserializer. It also takes two qualifiers with each completed byte: whether the byte was an address byte, and whether arbitration was lost in the acknowledge slot. From these inputs it decides, cycle by cycle, when the byte is loaded or captured and when each flag changes. Write collisions are deliberately not blocked: a new write always replaces the held byte.

Top module: `i2c_byte_buffer`

## Requirements
- R1: After synchronous reset, the register word reads 0x0000 and tx_empty, rx_not_empty and sh_tx_valid are all 0.
- R2: host_rdata always has bits 15:8 equal to zero and bits 7:0 equal to the held byte.
- R3: In transmit mode (tx_mode=1), a host write makes the byte pending from the next cycle: sh_tx_valid=1, tx_empty=0, and sh_tx_byte equals the written byte.
- R4: In transmit mode, sh_take while a byte is pending and no write occurs gives sh_tx_valid=0 and tx_empty=1 in the next cycle.
- R5: A write is accepted whatever the value of tx_empty, including while a byte is still pending, and it replaces the pending byte. A write in the same cycle as sh_take leaves tx_empty=0 and sh_tx_valid=1 with the new byte.
- R6: In receive mode (tx_mode=0), a completed byte (sh_rx_done) that is neither an address byte nor lost in the acknowledge slot is copied into the register, and rx_not_empty is 1 in the next cycle. The copy takes priority over a host write in the same cycle.
- R7: A completed byte flagged sh_rx_is_addr is not captured: the held byte and rx_not_empty are unchanged.
- R8: A completed byte flagged sh_rx_arb_lost_ack is not captured: the held byte and rx_not_empty are unchanged.
- R9: A host read clears rx_not_empty in the next cycle, unless a byte is captured in the same cycle, in which case rx_not_empty is 1.
- R10: A byte completed while rx_not_empty is still 1 replaces the held byte, and rx_not_empty stays 1.
- R11: While tx_mode=0, tx_empty and sh_tx_valid are 0 from the next cycle and sh_take has no effect. While tx_mode=1, sh_rx_done captures nothing.
- R12: A host write in receive mode updates the held byte but sets no pending transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 1 | 1 = transmitter, 0 = receiver |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 8 | Written byte (reserved upper bits not carried) |
| host_rd | input | 1 | Register read strobe |
| host_rdata | output | 16 | Register word, upper byte zero |
| tx_empty | output | 1 | Held byte taken by shifter |
| rx_not_empty | output | 1 | Received byte waiting |
| sh_tx_byte | output | 8 | Byte offered to serializer |
| sh_tx_valid | output | 1 | Byte pending for serializer |
| sh_take | input | 1 | Serializer loads the pending byte |
| sh_rx_done | input | 1 | Deserialized byte complete |
| sh_rx_byte | input | 8 | Deserialized byte |
| sh_rx_is_addr | input | 1 | Completed byte was an address byte |
| sh_rx_arb_lost_ack | input | 1 | Arbitration lost in acknowledge slot |

## Verification
The embedded properties check the cycle-to-cycle flag rules on every clock: take-to-empty, read-to-clear, the exclusion between pending and empty, and the forced clear in receive mode. They also check that a suppressed address or arbitration-lost byte leaves the register stable. Priority orderings need the bench's scenarios to show their outcome at the ports: write against take, capture against write, capture against read, and overwrite of an unread byte. The same holds for the exact byte values that travel through the register.

// File: rtl/i2c_byte_buffer_pkg.sv
package i2c_byte_buffer_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  done;
        logic  is_addr;
        logic  arb_lost_ack;
        byte_t data;
    } rx_evt_t;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_HOST = 2'd1,
        SRC_BUS  = 2'd2
    } load_src_e;

    // A completed byte enters the register only in receive mode, and only
    // when it is a data byte that survived the acknowledge slot.
    function automatic logic rx_qualifies(input rx_evt_t ev, input logic tx_mode);
        return ev.done && !tx_mode && !ev.is_addr && !ev.arb_lost_ack;
    endfunction

    // The bus capture outranks the host write.
    function automatic load_src_e pick_src(input logic cap, input logic wr);
        if (cap)     return SRC_BUS;
        else if (wr) return SRC_HOST;
        else         return SRC_HOLD;
    endfunction

endpackage

// File: rtl/dbuf_tx_ctrl.sv
module dbuf_tx_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic tx_mode,
    input  logic wr,
    input  logic take,
    output logic tx_empty,
    output logic pending
);

    logic pend_q, empty_q;

    always_ff @(posedge clk) begin
        if (rst || !tx_mode) begin
            pend_q  <= 1'b0;
            empty_q <= 1'b0;
        end else if (wr) begin
            pend_q  <= 1'b1;
            empty_q <= 1'b0;
        end else if (take && pend_q) begin
            pend_q  <= 1'b0;
            empty_q <= 1'b1;
        end
    end

    assign tx_empty = empty_q;
    assign pending  = pend_q;

    p_take_empties_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && take && pend_q && !wr) |=> (empty_q && !pend_q));

    p_write_pends_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && wr) |=> (pend_q && !empty_q));

    p_not_both_r5: assert property (@(posedge clk) disable iff (rst)
        !(pend_q && empty_q));

    p_rx_mode_clears_r11: assert property (@(posedge clk) disable iff (rst)
        !tx_mode |=> (!empty_q && !pend_q));

endmodule

// File: rtl/dbuf_rx_gate.sv
module dbuf_rx_gate
    import i2c_byte_buffer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tx_mode,
    input  rx_evt_t ev,
    input  logic    rd,
    output logic    cap_en,
    output logic    rx_full
);

    logic full_q;

    assign cap_en = rx_qualifies(ev, tx_mode);

    always_ff @(posedge clk) begin
        if (rst)         full_q <= 1'b0;
        else if (cap_en) full_q <= 1'b1;
        else if (rd)     full_q <= 1'b0;
    end

    assign rx_full = full_q;

    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (rd && !ev.done) |=> !full_q);

    p_addr_skips_r7: assert property (@(posedge clk) disable iff (rst)
        (ev.done && ev.is_addr && !rd) |=> $stable(full_q));

    p_arb_skips_r8: assert property (@(posedge clk) disable iff (rst)
        (ev.done && ev.arb_lost_ack && !rd) |=> $stable(full_q));

    p_tx_no_capture_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && !full_q) |=> !full_q);

endmodule

// File: rtl/dbuf_data_reg.sv
module dbuf_data_reg
    import i2c_byte_buffer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  byte_t wbyte,
    input  logic  cap_en,
    input  byte_t rbyte,
    output byte_t data
);

    byte_t     data_q;
    load_src_e src;

    assign src = pick_src(cap_en, wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            unique case (src)
                SRC_BUS:  data_q <= rbyte;
                SRC_HOST: data_q <= wbyte;
                default:  data_q <= data_q;
            endcase
        end
    end

    assign data = data_q;

    p_bus_wins_r6: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (data_q == $past(rbyte)));

    p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !wr) |=> $stable(data_q));

endmodule

// File: rtl/i2c_byte_buffer.sv
module i2c_byte_buffer
    import i2c_byte_buffer_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_mode,
    input  logic             host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic             host_rd,
    output logic [REG_W-1:0] host_rdata,
    output logic             tx_empty,
    output logic             rx_not_empty,
    output logic [BYTE_W-1:0] sh_tx_byte,
    output logic             sh_tx_valid,
    input  logic             sh_take,
    input  logic             sh_rx_done,
    input  logic [BYTE_W-1:0] sh_rx_byte,
    input  logic             sh_rx_is_addr,
    input  logic             sh_rx_arb_lost_ack
);

    localparam int PAD_W = REG_W - BYTE_W;

    rx_evt_t ev;
    logic    cap_en;
    byte_t   held;

    assign ev = '{done: sh_rx_done, is_addr: sh_rx_is_addr,
                  arb_lost_ack: sh_rx_arb_lost_ack, data: sh_rx_byte};

    dbuf_tx_ctrl u_tx (
        .clk      (clk),
        .rst      (rst),
        .tx_mode  (tx_mode),
        .wr       (host_wr),
        .take     (sh_take),
        .tx_empty (tx_empty),
        .pending  (sh_tx_valid)
    );

    dbuf_rx_gate u_rx (
        .clk     (clk),
        .rst     (rst),
        .tx_mode (tx_mode),
        .ev      (ev),
        .rd      (host_rd),
        .cap_en  (cap_en),
        .rx_full (rx_not_empty)
    );

    dbuf_data_reg u_data (
        .clk    (clk),
        .rst    (rst),
        .wr     (host_wr),
        .wbyte  (host_wdata),
        .cap_en (cap_en),
        .rbyte  (ev.data),
        .data   (held)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign host_rdata = {{PAD_W{1'b0}}, held};
        end else begin : g_nopad
            assign host_rdata = held[REG_W-1:0];
        end
    endgenerate

    assign sh_tx_byte = held;

    p_write_seen_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && host_wr && !sh_rx_done) |=> (sh_tx_byte == $past(host_wdata)));

    p_drop_keeps_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (sh_rx_done && sh_rx_arb_lost_ack && !host_wr) |=> $stable(host_rdata));

    p_rx_write_no_pend_r12: assert property (@(posedge clk) disable iff (rst)
        (!tx_mode && host_wr) |=> !sh_tx_valid);

endmodule

// File: tb/i2c_byte_buffer_tb_top.sv
module i2c_byte_buffer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        tx_mode, host_wr, host_rd, sh_take;
    logic        sh_rx_done, sh_rx_is_addr, sh_rx_arb_lost_ack;
    logic [7:0]  host_wdata, sh_rx_byte, sh_tx_byte;
    logic [15:0] host_rdata;
    logic        tx_empty, rx_not_empty, sh_tx_valid;

    int checks = 0;
    int failures = 0;

    // reference state
    logic [7:0] m_data;
    logic       m_te, m_pend, m_rxne;

    always #2 clk = ~clk;

    i2c_byte_buffer dut_i (
        .clk(clk), .rst(rst), .tx_mode(tx_mode),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_empty(tx_empty), .rx_not_empty(rx_not_empty),
        .sh_tx_byte(sh_tx_byte), .sh_tx_valid(sh_tx_valid),
        .sh_take(sh_take), .sh_rx_done(sh_rx_done), .sh_rx_byte(sh_rx_byte),
        .sh_rx_is_addr(sh_rx_is_addr), .sh_rx_arb_lost_ack(sh_rx_arb_lost_ack)
    );

    function automatic logic f_capture(logic tm, logic done, logic addr, logic arb);
        return !tm && done && !addr && !arb;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        host_wr = 0; host_rd = 0; sh_take = 0; sh_rx_done = 0;
        sh_rx_is_addr = 0; sh_rx_arb_lost_ack = 0;
        host_wdata = 8'h00; sh_rx_byte = 8'h00;
    endtask

    // advance the model with the inputs now applied, clock once, compare
    task automatic step(string req);
        logic cap;
        cap = f_capture(tx_mode, sh_rx_done, sh_rx_is_addr, sh_rx_arb_lost_ack);
        if (cap)          m_data = sh_rx_byte;
        else if (host_wr) m_data = host_wdata;
        if (cap)          m_rxne = 1;
        else if (host_rd) m_rxne = 0;
        if (!tx_mode)     begin m_pend = 0; m_te = 0; end
        else if (host_wr) begin m_pend = 1; m_te = 0; end
        else if (sh_take && m_pend) begin m_pend = 0; m_te = 1; end
        @(posedge clk); #1;
        chk({req, " rdata"}, host_rdata, {8'h00, m_data});
        chk({req, " tx_byte"}, sh_tx_byte, m_data);
        chk({req, " tx_empty"}, tx_empty, m_te);
        chk({req, " tx_valid"}, sh_tx_valid, m_pend);
        chk({req, " rxne"}, rx_not_empty, m_rxne);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin : watchdog
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        tx_mode = 1; rst = 1;
        m_data = 0; m_te = 0; m_pend = 0; m_rxne = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1: reset state
        chk("R1 rdata", host_rdata, 16'h0000);
        chk("R1 flags", {tx_empty, rx_not_empty, sh_tx_valid}, 3'b000);

        // R3 write in tx mode
        host_wr = 1; host_wdata = 8'hA5; step("R3");
        // R4 shifter takes
        sh_take = 1; step("R4");
        // R5 write with tx_empty=1 then write while pending
        host_wr = 1; host_wdata = 8'h3C; step("R5 first");
        host_wr = 1; host_wdata = 8'hC3; step("R5 collision");
        host_wr = 1; host_wdata = 8'h77; sh_take = 1; step("R5 write vs take");
        sh_take = 1; step("R4 take after");
        // R11 leave tx mode: flags clear, take ignored, rx ignored in tx first
        sh_rx_done = 1; sh_rx_byte = 8'hEE; step("R11 rx in tx mode");
        tx_mode = 0; step("R11 enter rx");
        sh_take = 1; step("R11 take ignored");
        // R12 write in rx mode
        host_wr = 1; host_wdata = 8'h12; step("R12");
        // R6 capture, capture beats write
        sh_rx_done = 1; sh_rx_byte = 8'h5A; host_wr = 1; host_wdata = 8'h99; step("R6");
        // R9 read clears
        host_rd = 1; step("R9 clear");
        // R7 address byte skipped
        sh_rx_done = 1; sh_rx_is_addr = 1; sh_rx_byte = 8'hF0; step("R7");
        // R8 arbitration lost skipped
        sh_rx_done = 1; sh_rx_arb_lost_ack = 1; sh_rx_byte = 8'h0F; step("R8");
        // R10 overwrite unread
        sh_rx_done = 1; sh_rx_byte = 8'h11; step("R10 first");
        sh_rx_done = 1; sh_rx_byte = 8'h22; step("R10 overwrite");
        // R9 read with simultaneous capture
        host_rd = 1; sh_rx_done = 1; sh_rx_byte = 8'h33; step("R9 read vs capture");
        host_rd = 1; step("R9 read");
        chk("R2 upper zero", host_rdata[15:8], 8'h00);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 31) == 0) tx_mode = ~tx_mode;
            host_wr    = ($urandom_range(0, 3) == 0);
            host_wdata = 8'($urandom);
            host_rd    = ($urandom_range(0, 2) == 0);
            sh_take    = ($urandom_range(0, 2) == 0);
            sh_rx_done = ($urandom_range(0, 2) == 0);
            sh_rx_byte = 8'($urandom);
            sh_rx_is_addr      = ($urandom_range(0, 5) == 0);
            sh_rx_arb_lost_ack = ($urandom_range(0, 5) == 0);
            step("R2-mix");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule